// File: doc/BRIEF.md
# Sync-Gated Video Line Capture Controller

This block sequences the capture of one monochrome video field into an external byte-wide SRAM. An 8-bit ADC drives the RAM data bus directly. This controller only decides when the ADC samples and where each byte lands. It does this through a sample-enable output, a RAM address and a write strobe. The core runs on a 10 MHz clock. Pixel work happens on every second clock, so one pixel lasts 200 ns. A host asks for a capture with a one-cycle start request. The controller then arms and waits for the next vertical sync before it handles any line.

In each line, a rising horizontal sync edge starts a programmable pre-window delay. A sampling window of programmable length follows the delay, and each of its pixels writes one byte at the next consecutive address. The 2-clock pixel divider restarts on the detected sync edge. Because of this, the time from sync edge to the first sample is a fixed number of clocks on every line, and lines do not shift sideways against each other. The next vertical sync ends the field and raises a done flag for the readout engine. The host clears that flag with an acknowledge. The host sets the delay and length in pixel ticks on configuration inputs, and the block copies them into registers when it accepts a start. The register defaults are 20 ticks (4 µs) and 250 ticks (50 µs).

Top module: `line_capture_ctrl`

## Requirements
- R1: While reset is held and after it is released, busy, done, sample_en, ram_we and overflow are 0 and ram_addr is 0.
- R2: A start_req seen in idle makes busy 1 on the next clock. Until a rising vsync is seen after that, no hsync edge opens a window, so sample_en and ram_we stay 0.
- R3: If hsync rises just before clock edge k while a field is capturing, sample_en goes to 1 after edge k+2·D+2, where D is the captured delay. This count is the same on every line, whatever the spacing between lines.
- R4: A window keeps sample_en at 1 for exactly 2·W clocks, where W is the captured length. ram_we is 1 on every second clock of the window, starting with its second clock. The window writes W bytes.
- R5: ram_addr moves by exactly 1 on each write and by nothing otherwise. The count carries on across lines, and accepting a start clears it to 0.
- R6: A rising hsync edge that arrives while a line's delay or window is still running is ignored and opens no second window.
- R7: A rising vsync during capture drops sample_en within 3 clocks, even mid-window, and sets done while busy stays 1. After that, no further writes happen.
- R8: done stays at 1 until done_ack is sampled high. One clock later, busy and done are both 0.
- R9: A start_req while busy is ignored. Busy stays 1, the address is not cleared, and the configuration is not reloaded.
- R10: When a write lands on the last address (2^ADDR_W−1), ram_addr wraps to 0 and overflow goes to 1. overflow stays at 1 until the next accepted start.
- R11: The block captures cfg_delay and cfg_width only when it accepts a start, and a captured value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Host capture request, one clock wide, synchronous to clk |
| done_ack | input | 1 | Host acknowledge that clears done |
| vsync_in | input | 1 | Vertical sync level from the separator (asynchronous) |
| hsync_in | input | 1 | Horizontal sync level from the separator (asynchronous) |
| cfg_delay | input | DLY_W | Pre-window delay in pixel ticks, copied on start |
| cfg_width | input | WID_W | Window length in pixel ticks, copied on start |
| busy | output | 1 | Capture armed, running or waiting for acknowledge |
| done | output | 1 | Field finished, data ready for readout |
| sample_en | output | 1 | Sampling window open, enables the ADC |
| ram_we | output | 1 | One-clock write strobe per pixel |
| ram_addr | output | ADDR_W | Address for the current byte |
| overflow | output | 1 | The field wrapped the address space |

## Verification
The assertions assume that both sync inputs stay high for at least two clocks so the synchronizer can see each edge. They also assume that start_req and done_ack are synchronous to clk, and that the configuration inputs are stable in the cycle a start is accepted. The stimulus drives every input one nanosecond after a rising edge. It holds each sync pulse high for three clocks and lets it fall well before the next one. It changes the configuration inputs only away from an accepted start, except when it deliberately changes them during capture to show they are not reloaded. The gaps between lines vary between odd and even clock counts. This exposes any pixel phase that is not restarted from the sync edge.

// File: rtl/lcap_pkg.sv
package lcap_pkg;

  typedef enum logic [1:0] {
    FLD_IDLE    = 2'd0,
    FLD_ARMED   = 2'd1,
    FLD_CAPTURE = 2'd2,
    FLD_DONE    = 2'd3
  } fld_state_t;

  typedef enum logic [1:0] {
    LN_IDLE   = 2'd0,
    LN_DELAY  = 2'd1,
    LN_WINDOW = 2'd2
  } ln_state_t;

endpackage

// File: rtl/lcap_edge_sync.sv
module lcap_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= din[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise[i] = sync_q & ~prev_q;
  end

endmodule

// File: rtl/lcap_line_timer.sv
module lcap_line_timer
  import lcap_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int WID_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hs_rise,
  input  logic [DLY_W-1:0] dly,
  input  logic [WID_W-1:0] wid,
  output logic             sample_en,
  output logic             pix_we
);

  localparam int CW = ((DLY_W > WID_W) ? DLY_W : WID_W) + 1;

  ln_state_t st_q, st_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic ph_q, ph_nx;
  logic tick;
  logic [CW-1:0] cnt_inc;

  assign tick    = ph_q && (st_q != LN_IDLE);
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    st_nx  = st_q;
    cnt_nx = cnt_q;
    ph_nx  = (st_q == LN_IDLE) ? 1'b0 : ~ph_q;
    unique case (st_q)
      LN_IDLE: begin
        if (run && hs_rise) begin
          st_nx  = LN_DELAY;
          cnt_nx = '0;
          ph_nx  = 1'b0;
        end
      end
      LN_DELAY: begin
        if (tick) begin
          if (cnt_inc >= CW'(dly)) begin
            st_nx  = LN_WINDOW;
            cnt_nx = '0;
          end else begin
            cnt_nx = cnt_inc;
          end
        end
      end
      LN_WINDOW: begin
        if (tick) begin
          if (cnt_inc >= CW'(wid)) begin
            st_nx  = LN_IDLE;
            cnt_nx = '0;
          end else begin
            cnt_nx = cnt_inc;
          end
        end
      end
      default: st_nx = LN_IDLE;
    endcase
    if (!run) begin
      st_nx  = LN_IDLE;
      cnt_nx = '0;
      ph_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      st_q  <= st_nx;
      cnt_q <= cnt_nx;
      ph_q  <= ph_nx;
    end
  end

  assign sample_en = (st_q == LN_WINDOW);
  assign pix_we    = sample_en && ph_q;

  // R4: writes are paced at one pixel per two clocks
  assert_we_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we |=> !pix_we);

  // R4: a window closes only right after a write tick or on an abort
  assert_window_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_en) |-> ($past(pix_we) || !$past(run)));

  // R6: a sync edge during an open window does not restart the line
  assert_hs_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !pix_we && run) |=> sample_en || !run);

endmodule

// File: rtl/lcap_addr_ctr.sv
module lcap_addr_ctr #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          ovf
);

  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic [AW-1:0] addr_nx;
  logic          ovf_nx;

  always_comb begin
    addr_nx = addr;
    ovf_nx  = ovf;
    if (clr) begin
      addr_nx = '0;
      ovf_nx  = 1'b0;
    end else if (adv) begin
      addr_nx = addr + 1'b1;
      if (addr == LAST) ovf_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      ovf  <= 1'b0;
    end else begin
      addr <= addr_nx;
      ovf  <= ovf_nx;
    end
  end

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> addr == $past(addr) + 1'b1);

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(addr));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);

endmodule

// File: rtl/line_capture_ctrl.sv
module line_capture_ctrl
  import lcap_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DLY_W   = 8,
  parameter int WID_W   = 9,
  parameter int DEF_DLY = 20,
  parameter int DEF_WID = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              done_ack,
  input  logic              vsync_in,
  input  logic              hsync_in,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [WID_W-1:0]  cfg_width,
  output logic              busy,
  output logic              done,
  output logic              sample_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              overflow
);

  localparam int SYNC_N = 2;
  localparam int VS_BIT = 1;
  localparam int HS_BIT = 0;

  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  logic [SYNC_N-1:0] sync_rise;
  logic vs_rise, hs_rise;

  lcap_edge_sync #(.N(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rs_q),
    .din   ({vsync_in, hsync_in}),
    .rise  (sync_rise)
  );
  assign vs_rise = sync_rise[VS_BIT];
  assign hs_rise = sync_rise[HS_BIT];

  fld_state_t st_q, st_nx;
  logic accept;
  logic run;
  logic [DLY_W-1:0] dly_q;
  logic [WID_W-1:0] wid_q;

  assign accept = (st_q == FLD_IDLE) && start_req;

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      FLD_IDLE:    if (start_req) st_nx = FLD_ARMED;
      FLD_ARMED:   if (vs_rise)   st_nx = FLD_CAPTURE;
      FLD_CAPTURE: if (vs_rise)   st_nx = FLD_DONE;
      FLD_DONE:    if (done_ack)  st_nx = FLD_IDLE;
      default:                    st_nx = FLD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      st_q  <= FLD_IDLE;
      dly_q <= DLY_W'(DEF_DLY);
      wid_q <= WID_W'(DEF_WID);
    end else begin
      st_q <= st_nx;
      if (accept) begin
        dly_q <= cfg_delay;
        wid_q <= cfg_width;
      end
    end
  end

  assign run  = (st_nx == FLD_CAPTURE);
  assign busy = (st_q != FLD_IDLE);
  assign done = (st_q == FLD_DONE);

  lcap_line_timer #(.DLY_W(DLY_W), .WID_W(WID_W)) u_timer (
    .clk       (clk),
    .rst_n     (rs_q),
    .run       (run),
    .hs_rise   (hs_rise),
    .dly       (dly_q),
    .wid       (wid_q),
    .sample_en (sample_en),
    .pix_we    (ram_we)
  );

  lcap_addr_ctr #(.AW(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rs_q),
    .clr   (accept),
    .adv   (ram_we),
    .addr  (ram_addr),
    .ovf   (overflow)
  );

  assert_armed_quiet_R2: assert property (@(posedge clk) disable iff (!rs_q)
    (st_q == FLD_ARMED) |-> !sample_en);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rs_q)
    done |-> (!sample_en && !ram_we));

  assert_ack_idle_R8: assert property (@(posedge clk) disable iff (!rs_q)
    (done && done_ack) |=> !busy);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rs_q)
    (busy && !done) |=> busy);

endmodule

// File: tb/line_capture_ctrl_tb.sv
`timescale 1ns/1ps
module line_capture_ctrl_tb_top;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int D     = 3;
  localparam int W     = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start_req = 1'b0;
  logic          done_ack = 1'b0;
  logic          vsync_in = 1'b0;
  logic          hsync_in = 1'b0;
  logic [7:0]    cfg_delay = 8'd0;
  logic [8:0]    cfg_width = 9'd0;
  logic          busy, done, sample_en, ram_we, overflow;
  logic [AW-1:0] ram_addr;

  line_capture_ctrl #(.ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .done_ack  (done_ack),
    .vsync_in  (vsync_in),
    .hsync_in  (hsync_in),
    .cfg_delay (cfg_delay),
    .cfg_width (cfg_width),
    .busy      (busy),
    .done      (done),
    .sample_en (sample_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .overflow  (overflow)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  int exp_addr = 0;
  bit sb_on = 1'b0;
  int last_lat, last_win;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // scoreboard monitor: pop expected addresses as the design writes
  always @(negedge clk) begin
    int e;
    if (sb_on && ram_we) begin
      chk("R4 write strobe inside window", int'(sample_en), 1);
      if (exp_q.size() == 0) begin
        chk("R5 unexpected write", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk("R5 write address", int'(ram_addr), e);
      end
    end
  end

  // driver side: predict the addresses of one line
  task automatic push_line(int w);
    repeat (w) begin
      exp_q.push_back(exp_addr);
      exp_addr = (exp_addr + 1) % DEPTH;
    end
  endtask

  task automatic pulse_vsync();
    vsync_in = 1'b1;
    repeat (3) tick();
    vsync_in = 1'b0;
    tick();
  endtask

  task automatic do_start();
    start_req = 1'b1;
    tick();
    start_req = 1'b0;
  endtask

  task automatic run_line(int d, int w, int gap, bit extra_hs);
    int n;
    int m;
    int seen;
    repeat (gap) tick();
    push_line(w);
    hsync_in = 1'b1;
    n = 0;
    do begin
      tick();
      n++;
      if (n == 3) hsync_in = 1'b0;
    end while (!sample_en && n < 200);
    hsync_in = 1'b0;
    last_lat = n;
    chk("R3 hsync-to-window latency", n, 2*d + 3);
    m = 0;
    while (sample_en && m < 2000) begin
      tick();
      m++;
      if (extra_hs && m == 4) hsync_in = 1'b1;
      if (extra_hs && m == 6) hsync_in = 1'b0;
    end
    last_win = m;
    chk("R4 window length", m, 2*w);
    chk("R4 writes per line", exp_q.size(), 0);
    if (extra_hs) begin
      seen = 0;
      repeat (2*d + 2*w + 6) begin
        tick();
        if (sample_en) seen++;
      end
      chk("R6 hsync inside window ignored", seen, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    report();
    $finish;
  end

  initial begin
    int seen;
    // R1: reset state
    repeat (3) tick();
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 sample_en in reset", int'(sample_en), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ram_we", int'(ram_we), 0);
    chk("R1 ram_addr", int'(ram_addr), 0);
    chk("R1 overflow", int'(overflow), 0);

    // R2: arm, hsync before vsync ignored
    cfg_delay = 8'(D);
    cfg_width = 9'(W);
    sb_on = 1'b1;
    do_start();
    chk("R2 busy after start", int'(busy), 1);
    cfg_delay = 8'd5;
    cfg_width = 9'd2;
    hsync_in = 1'b1;
    repeat (3) tick();
    hsync_in = 1'b0;
    seen = 0;
    repeat (40) begin
      tick();
      if (sample_en) seen++;
    end
    chk("R2 no window while armed", seen, 0);

    pulse_vsync();
    // lines 1..7 with gaps of varying parity; R11 config captured at start
    run_line(D, W, 3, 1'b0);
    chk("R11 latency uses captured delay", last_lat, 2*D + 3);
    chk("R11 window uses captured width", last_win, 2*W);
    run_line(D, W, 4, 1'b0);
    run_line(D, W, 5, 1'b1);
    run_line(D, W, 6, 1'b0);
    // R9: start while busy is ignored
    do_start();
    chk("R9 busy kept", int'(busy), 1);
    chk("R9 address not cleared", int'(ram_addr), 4*W);
    run_line(D, W, 7, 1'b0);
    run_line(D, W, 2, 1'b0);
    run_line(D, W, 9, 1'b0);
    chk("R10 no overflow before wrap", int'(overflow), 0);
    chk("R5 address after seven lines", int'(ram_addr), 7*W);
    run_line(D, W, 4, 1'b0);
    chk("R10 overflow after wrap", int'(overflow), 1);
    chk("R10 address wrapped", int'(ram_addr), 0);
    run_line(D, W, 3, 1'b0);
    chk("R10 overflow sticky", int'(overflow), 1);

    // R7: vsync ends the field
    repeat (3) tick();
    pulse_vsync();
    chk("R7 done", int'(done), 1);
    chk("R7 busy", int'(busy), 1);
    hsync_in = 1'b1;
    repeat (3) tick();
    hsync_in = 1'b0;
    seen = 0;
    repeat (40) begin
      tick();
      if (sample_en) seen++;
    end
    chk("R7 no window after field end", seen, 0);
    chk("R8 done held", int'(done), 1);
    // R8: acknowledge
    done_ack = 1'b1;
    tick();
    done_ack = 1'b0;
    chk("R8 busy cleared", int'(busy), 0);
    chk("R8 done cleared", int'(done), 0);
    chk("R10 overflow kept until start", int'(overflow), 1);

    // second field: zero configuration acts as one
    cfg_delay = 8'd0;
    cfg_width = 9'd0;
    do_start();
    exp_addr = 0;
    chk("R5 start clears address", int'(ram_addr), 0);
    chk("R10 start clears overflow", int'(overflow), 0);
    pulse_vsync();
    run_line(1, 1, 3, 1'b0);
    chk("R11 zero delay as one", last_lat, 5);
    chk("R11 zero width as one", last_win, 2);
    pulse_vsync();
    done_ack = 1'b1;
    tick();
    done_ack = 1'b0;

    // third field: vsync aborts an open window
    sb_on = 1'b0;
    cfg_delay = 8'd2;
    cfg_width = 9'd20;
    do_start();
    pulse_vsync();
    repeat (2) tick();
    hsync_in = 1'b1;
    seen = 0;
    while (!sample_en && seen < 100) begin
      tick();
      seen++;
    end
    hsync_in = 1'b0;
    repeat (5) tick();
    chk("R7 window open before abort", int'(sample_en), 1);
    vsync_in = 1'b1;
    repeat (3) tick();
    chk("R7 window dropped by vsync", int'(sample_en), 0);
    chk("R7 done after abort", int'(done), 1);
    vsync_in = 1'b0;
    done_ack = 1'b1;
    tick();
    done_ack = 1'b0;
    chk("R8 idle after abort ack", int'(busy), 0);

    report();
    $finish;
  end

endmodule